// File: doc/BRIEF.md
# Sine Synthesizer with PWM Output

This block is a direct digital synthesis source whose output is a single pulse-width modulated pin. A 16-bit phase register grows by a 16-bit tuning word once every eight system clocks and wraps modulo 65536. The eight most significant phase bits select an entry of a 256-entry unsigned sine table. Each entry is an 8-bit amplitude centred on 128. That amplitude becomes the duty cycle of a free-running 8-bit PWM counter. The pin is meant to be smoothed by an external low-pass filter into a sine wave.

The tone frequency is tuning word × (fclk/8)/65536. With an 8 MHz clock one step of the tuning word is about 15.26 Hz, and a word of 2046 gives about 31.2 kHz. The tuning word may change at any time. The phase register is never cleared by such a change: the new word is used from the next phase step on.

A two-state sequencer sets the sample rate. `SEQ_WAIT` counts clocks. When its counter reaches the last waiting count, the transition *arm* moves it to `SEQ_STEP`. `SEQ_STEP` lasts exactly one clock, during which the phase register takes the tuning word. The transition *resume* then returns it unconditionally to `SEQ_WAIT` with a cleared counter. Reset enters `SEQ_WAIT` with the counter at zero.

Top module: `dds_pwm_synth`

## Requirements
- R1: After reset the PWM counter is 0 and the duty is 128, so the first PWM period is high for exactly 128 clocks and then low for 128 clocks.
- R2: The phase register adds `tune_word` exactly once per 8 clocks. The first addition happens at the 8th rising edge after reset is released, and each later one 8 edges after the previous one.
- R3: The table entry for index a (0..255) is 128+h when a<128 and 128−h when a≥128. Here x = a mod 128 and h = floor(x·(128−x)·127/4096). The index is phase bits [15:8].
- R4: The duty is reloaded only at the rising edge where the PWM counter steps from 255 to 0. It takes the table entry for the phase held before that edge, and stays unchanged for the whole of the following 256-clock period.
- R5: `pwm_o` is high exactly while the PWM counter is below the duty, so within one period the pin is high for the first `duty` clocks and then low.
- R6: A change of `tune_word` leaves the phase untouched. Each phase step uses the word present at its own edge.
- R7: Phase addition wraps modulo 65536.
- R8: The PWM counter runs freely 0..255 with a period of 256 clocks, independent of the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 16 | Phase increment per sample step |
| pwm_o | output | 1 | PWM output, duty follows the sine table |

## Verification
The main function is driven with constant tuning words applied from reset: zero, a small word (9), the top word in use (2046), and a large word (0xF3A1) that wraps the phase on nearly every step. For each period the number of high clocks is compared against a closed-form phase count. Zero separates the mid-scale start from real table reads. The small word shows that only the upper phase bits index the table. The top word and the wrapping word separate correct modulo arithmetic and step counting from off-by-one step timing. A further run changes the word in the middle of a period to show that the phase is carried over rather than cleared. A behavioural model is also compared with the pin on every clock, and the shape of each period (one high run then one low run, falling at the duty count) checks the compare and the reload timing.

// File: rtl/dds_pwm_pkg.sv
package dds_pwm_pkg;

    typedef enum logic [0:0] {
        SEQ_WAIT = 1'b0,
        SEQ_STEP = 1'b1
    } seq_state_e;

    // Parabolic sine approximation, one table entry per index.
    function automatic int sine_point(input int idx, input int addr_w, input int amp_w);
        int half;
        int quarter;
        int mid;
        int x;
        int h;
        half    = 1 << (addr_w - 1);
        quarter = half / 2;
        mid     = 1 << (amp_w - 1);
        x       = idx % half;
        h       = (x * (half - x) * (mid - 1)) / (quarter * quarter);
        return (idx < half) ? (mid + h) : (mid - h);
    endfunction

endpackage

// File: rtl/dds_sample_seq.sv
module dds_sample_seq
    import dds_pwm_pkg::*;
#(
    parameter int SAMPLE_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic step_o
);
    localparam int CNT_W = (SAMPLE_DIV > 2) ? $clog2(SAMPLE_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(SAMPLE_DIV - 2);

    seq_state_e       state_q;
    seq_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;

    // State register and wait counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_STEP) cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
        end
    end

    // Transitions: arm (WAIT->STEP), resume (STEP->WAIT)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_WAIT: if (cnt_q == LAST_WAIT) state_d = SEQ_STEP;
            SEQ_STEP: state_d = SEQ_WAIT;
            default:  state_d = SEQ_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        step_o = 1'b0;
        unique case (state_q)
            SEQ_WAIT: step_o = 1'b0;
            SEQ_STEP: step_o = 1'b1;
            default:  step_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_i,
    input  logic [PHASE_W-1:0] incr_i,
    output logic [PHASE_W-1:0] phase_o
);
    always_ff @(posedge clk) begin
        if (rst)         phase_o <= '0;
        else if (step_i) phase_o <= phase_o + incr_i;
    end
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
    import dds_pwm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int AMP_W  = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [AMP_W-1:0]  amp_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [AMP_W-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_q[i] = AMP_W'(sine_point(i, ADDR_W, AMP_W));
    end

    assign amp_o = table_q[addr_i];
endmodule

// File: rtl/dds_pwm_gen.sv
module dds_pwm_gen #(
    parameter int PWM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PWM_W-1:0] level_i,
    output logic [PWM_W-1:0] cnt_o,
    output logic [PWM_W-1:0] duty_o,
    output logic             pwm_o
);
    localparam logic [PWM_W-1:0] MID = PWM_W'(1 << (PWM_W - 1));

    logic wrap;
    assign wrap = &cnt_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o  <= '0;
            duty_o <= MID;
        end else begin
            cnt_o <= cnt_o + 1'b1;
            if (wrap) duty_o <= level_i;
        end
    end

    assign pwm_o = (cnt_o < duty_o);
endmodule

// File: rtl/dds_pwm_synth.sv
module dds_pwm_synth #(
    parameter int PHASE_W    = 16,
    parameter int ADDR_W     = 8,
    parameter int PWM_W      = 8,
    parameter int SAMPLE_DIV = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] tune_word,
    output logic               pwm_o
);
    logic               step;
    logic [PHASE_W-1:0] phase;
    logic [PWM_W-1:0]   level;
    logic [PWM_W-1:0]   pwm_cnt;
    logic [PWM_W-1:0]   duty_q;

    dds_sample_seq #(.SAMPLE_DIV(SAMPLE_DIV)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .step_o (step)
    );

    dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step),
        .incr_i  (tune_word),
        .phase_o (phase)
    );

    dds_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(PWM_W)) u_rom (
        .addr_i (phase[PHASE_W-1 -: ADDR_W]),
        .amp_o  (level)
    );

    dds_pwm_gen #(.PWM_W(PWM_W)) u_pwm (
        .clk     (clk),
        .rst     (rst),
        .level_i (level),
        .cnt_o   (pwm_cnt),
        .duty_o  (duty_q),
        .pwm_o   (pwm_o)
    );
endmodule

// File: rtl/dds_pwm_chk.sv
module dds_pwm_chk #(
    parameter int PHASE_W = 16,
    parameter int PWM_W   = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               step,
    input logic [PHASE_W-1:0] tune_word,
    input logic [PHASE_W-1:0] phase,
    input logic [PWM_W-1:0]   pwm_cnt,
    input logic [PWM_W-1:0]   duty_q
);
    localparam logic [PWM_W-1:0] MID = PWM_W'(1 << (PWM_W - 1));

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pwm_cnt == '0 && duty_q == MID));

    // R8
    free_count_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pwm_cnt == $past(pwm_cnt) + 1'b1);

    // R4
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm_cnt != '1) |=> $stable(duty_q));

    // R2
    phase_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(phase));

    // R7
    phase_add_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> phase == $past(phase) + $past(tune_word));

    // R2
    step_single_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);
endmodule

bind dds_pwm_synth dds_pwm_chk #(.PHASE_W(PHASE_W), .PWM_W(PWM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .tune_word (tune_word),
    .phase     (phase),
    .pwm_cnt   (pwm_cnt),
    .duty_q    (duty_q)
);

// File: tb/sim_dds_pwm_synth.sv
`timescale 1ns/1ps
module sim_dds_pwm_synth;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tune = 16'd0;
    logic        pwm;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dds_pwm_synth u0 (.clk(clk), .rst(rst), .tune_word(tune), .pwm_o(pwm));

    function automatic int ref_sine(int a);
        int x;
        int h;
        x = a % 128;
        h = (x * (128 - x) * 127) / 4096;
        if (a >= 128) return 128 - h;
        return 128 + h;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural model, one update per clock
    int m_div, m_phase, m_pcnt, m_cmp;
    always @(posedge clk) begin
        if (rst) begin
            m_div <= 0; m_phase <= 0; m_pcnt <= 0; m_cmp <= 128;
        end else begin
            if (m_pcnt == 255) m_cmp <= ref_sine(m_phase / 256);
            if (m_div == 7) m_phase <= (m_phase + int'(tune)) % 65536;
            m_div  <= (m_div + 1) % 8;
            m_pcnt <= (m_pcnt + 1) % 256;
        end
    end

    // R5: pin against model every clock
    always @(negedge clk) begin
        if (!rst && !finished)
            chk(pwm === (m_pcnt < m_cmp), "R5 per-clock", int'(pwm), int'(m_pcnt < m_cmp));
    end

    task automatic do_reset(input logic [15:0] t);
        @(negedge clk);
        rst  = 1'b1;
        tune = t;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Measures one PWM period starting at the current negedge.
    task automatic measure(input int switch_at, input logic [15:0] t2,
                           output int highs, output int first_low, output bit shape_ok);
        bit seen_low;
        highs = 0; first_low = 256; shape_ok = 1; seen_low = 0;
        for (int i = 0; i < 256; i++) begin
            if (i == switch_at) tune = t2;
            if (pwm) begin
                highs++;
                if (seen_low) shape_ok = 0;
            end else if (!seen_low) begin
                seen_low = 1;
                first_low = i;
            end
            @(negedge clk);
        end
    endtask

    task automatic const_run(input logic [15:0] t, input int periods, input string req);
        int h, fl, e;
        bit sh;
        do_reset(t);
        measure(-1, t, h, fl, sh);
        chk(h == 128, {req, " period0 mid-scale R1"}, h, 128);
        for (int p = 1; p <= periods; p++) begin
            measure(-1, t, h, fl, sh);
            e = ref_sine((((32 * p - 1) * int'(t)) % 65536) / 256);
            chk(h == e, {req, " duty R2 R3"}, h, e);
            chk(sh, {req, " one high run R4"}, int'(sh), 1);
            chk(fl == h, {req, " falls at duty R8"}, fl, h);
        end
    endtask

    initial begin
        int h, fl, e;
        bit sh;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);

        // R1: reset state, zero tune keeps mid-scale
        do_reset(16'd0);
        measure(-1, 16'd0, h, fl, sh);
        chk(h == 128, "R1 first period highs", h, 128);
        chk(fl == 128, "R1 first period fall", fl, 128);
        measure(-1, 16'd0, h, fl, sh);
        chk(h == 128, "R3 zero tune index 0", h, 128);

        const_run(16'd9,    2, "R3 small word");
        const_run(16'd2046, 4, "R2 top word");
        const_run(16'hF3A1, 4, "R7 wrapping word");
        const_run(16'h0200, 3, "R2 mid word");

        // R6: tune change mid-period, phase carried over
        do_reset(16'd700);
        measure(-1, 16'd700, h, fl, sh);
        chk(h == 128, "R6 period0", h, 128);
        measure(300 - 256, 16'd3000, h, fl, sh);
        e = ref_sine(((31 * 700) % 65536) / 256);
        chk(h == e, "R6 period1 before change", h, e);
        measure(-1, 16'd3000, h, fl, sh);
        e = ref_sine(((37 * 700 + 26 * 3000) % 65536) / 256);
        chk(h == e, "R6 period2 after change", h, e);
        chk(sh, "R4 single run after change", int'(sh), 1);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule